// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a requester that issues word reads and a slower word-addressed backing memory. It holds 16 KB of data in 1024 lines of 16 bytes. Each line keeps one valid flag and one stored tag. A 32-bit byte address is split into three unsigned fields. The lowest four bits pick a byte inside a line, and of these only bits [3:2] matter because reads return whole words. The next ten bits pick the line. The top eighteen bits are compared with the tag stored in that line.

When the selected line is valid and its tag matches, the word is returned on the next cycle and memory is not touched. Otherwise the block fetches the whole line from memory as four word reads, each with its own request/acknowledge handshake. It then writes the tag, sets the valid flag and returns the requested word. Every response carries an outcome code: a hit, a miss into an empty line, or a miss that evicts a line holding another tag. Whatever the outcome, the returned word always equals the memory contents at that address.

Top module: `dmc_read_cache`

## Requirements
- R1: After reset, and after any later reset, every line is empty: `req_ready`=1, `busy`=0, `resp_valid`=0, `mem_req`=0, and the first read to any address reports outcome 01.
- R2: Address fields are unsigned: byte offset = bits [3:0], line index = bits [13:4], tag = bits [31:14]. The word is chosen by bits [3:2], and bits [1:0] have no effect on the result.
- R3: A read to a valid line whose stored tag equals the address tag reports outcome 00. `resp_valid` rises in the cycle after the accepting clock edge, and no memory read is made.
- R4: A read to an invalid line reports outcome 01. It makes exactly four memory reads, at the line base address +0, +4, +8 and +12 in that order, and then marks the line valid with the new tag.
- R5: A read to a valid line holding a different tag reports outcome 10. It replaces the line and its tag, so a later read with the evicted tag misses again with outcome 10.
- R6: `resp_data` always equals the backing-memory word at the requested address, whatever the outcome.
- R7: While a refill is in progress `busy`=1 and `req_ready`=0. `mem_addr` is held stable while `mem_req` is high and `mem_ack` is low.
- R8: Each accepted request gives exactly one single-cycle `resp_valid` pulse. A miss responds in the cycle after its fourth acknowledged memory read, and the outcome code is never 11.
- R9: Refilling one line leaves the contents and state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | Byte address of the read |
| resp_valid | output | 1 | One-cycle pulse: response data and outcome valid |
| resp_data | output | 32 | Word read |
| resp_kind | output | 2 | Outcome: 00 hit, 01 miss into empty line, 10 miss with eviction |
| busy | output | 1 | Refill in progress |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_ack | input | 1 | Memory has returned `mem_rdata` for `mem_addr` |
| mem_rdata | input | 32 | Memory read data |

## Verification
A hit must raise `resp_valid` in the cycle after the accepting edge. The bench samples on falling edges and requires the response at the first falling edge after acceptance. A miss may take a variable number of cycles, since the bench memory acknowledges every other cycle. For a miss the bench therefore waits for the pulse under a bounded count, while it logs every acknowledged memory read and compares the number of reads and their order with the outcome expected. The sample right after each response confirms that the pulse lasted one cycle. The first sample after a miss is accepted confirms that the block reports busy and refuses new requests.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped read cache.
package dmc_pkg;
    // Outcome code sent with every response.
    typedef enum logic [1:0] {
        OUT_HIT   = 2'b00,
        OUT_COLD  = 2'b01,
        OUT_EVICT = 2'b10
    } outcome_e;
endpackage

// File: rtl/dmc_tag_store.sv
// Valid flags and tags, one entry per line.
// Read is combinational. A write stores the tag and sets the valid flag.
// Assumes at most one write per cycle. Reset clears every valid flag.
module dmc_tag_store #(
    parameter int LINES = 1024,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    // Valid flags: cleared by reset, set when a line is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    // Tag storage: written on fill, needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en)
            tag_mem[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];

    // R1: the cache is empty when reset is released.
    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

    // R4: a filled line is valid from the next cycle on.
    assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/dmc_data_store.sv
// Line data held as one bank per word position.
// Read is combinational, at (index, word). A write updates one word of one line.
// Assumes WORDS is a power of two and at least 2.
module dmc_data_store #(
    parameter int LINES  = 1024,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] bank_rd [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [DATA_W-1:0] bank [LINES];

        // Bank write: only when this word position is targeted.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_word == WSEL_W'(w)))
                bank[wr_idx] <= wr_data;
        end

        assign bank_rd[w] = bank[rd_idx];
    end

    assign rd_data = bank_rd[rd_word];
endmodule

// File: rtl/dmc_refill_ctrl.sv
// Refill sequencer: on start it reads every word of one line from memory in
// ascending order, one request/acknowledge handshake per word.
// Assumes memory holds mem_ack low except to accept the current mem_addr.
module dmc_refill_ctrl #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 4,
    parameter int WB_W   = 2,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = ADDR_W - WSEL_W - WB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic              mem_ack,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat,
    output logic              last_beat,
    output logic [WSEL_W-1:0] word_cnt
);
    typedef enum logic {ST_IDLE, ST_FETCH} state_e;

    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

    state_e            state_q;
    logic [WSEL_W-1:0] cnt_q;
    logic [LINE_W-1:0] line_q;

    // Sequencer state, word counter and latched line number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            line_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_FETCH;
                        cnt_q   <= '0;
                        line_q  <= start_line;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_WORD)
                            state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == ST_FETCH);
    assign mem_req   = busy;
    assign mem_addr  = {line_q, cnt_q, {WB_W{1'b0}}};
    assign beat      = mem_req && mem_ack;
    assign last_beat = beat && (cnt_q == LAST_WORD);
    assign word_cnt  = cnt_q;

    // R7: a pending memory request keeps its address until acknowledged.
    assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7: a new refill is never started while one is running.
    assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R4: a refill ends only after its final word, never earlier.
    assert_ends_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_beat) |=> busy);
endmodule

// File: rtl/dmc_read_cache.sv
// Direct-mapped read-only cache. It looks up the requested address in the
// same cycle it is accepted and answers a hit on the next cycle. A miss starts
// a full-line refill and answers after the last word arrives.
// Assumes requests are accepted only while idle, reads only.
module dmc_read_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic [1:0]        resp_kind,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WB_W       = $clog2(WORD_BYTES);
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W     = ADDR_W - OFF_W;

    // Address fields of the incoming request.
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic              unused_byte_bits;

    assign req_tag          = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx          = req_addr[OFF_W +: IDX_W];
    assign req_word         = req_addr[WB_W +: WSEL_W];
    assign unused_byte_bits = ^req_addr[WB_W-1:0];

    // Request latched for the refill.
    logic [TAG_W-1:0]  lat_tag;
    logic [IDX_W-1:0]  lat_idx;
    logic [WSEL_W-1:0] lat_word;
    outcome_e          lat_kind;

    logic              look_valid;
    logic [TAG_W-1:0]  look_tag;
    logic [DATA_W-1:0] look_data;
    logic              hit;
    logic              accept;
    logic              start;

    logic              fill_busy;
    logic              beat;
    logic              last_beat;
    logic [WSEL_W-1:0] word_cnt;

    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;
    outcome_e          resp_kind_q;

    dmc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (look_valid),
        .rd_tag   (look_tag),
        .wr_en    (last_beat),
        .wr_idx   (lat_idx),
        .wr_tag   (lat_tag)
    );

    dmc_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (look_data),
        .wr_en   (beat),
        .wr_idx  (lat_idx),
        .wr_word (word_cnt),
        .wr_data (mem_rdata)
    );

    dmc_refill_ctrl #(
        .ADDR_W (ADDR_W),
        .WORDS  (WORDS),
        .WB_W   (WB_W)
    ) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_line (req_addr[ADDR_W-1 -: LINE_W]),
        .mem_ack    (mem_ack),
        .busy       (fill_busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .beat       (beat),
        .last_beat  (last_beat),
        .word_cnt   (word_cnt)
    );

    assign req_ready = !fill_busy;
    assign busy      = fill_busy;
    assign accept    = req_valid && req_ready;
    assign hit       = look_valid && (look_tag == req_tag);
    assign start     = accept && !hit;

    // Latch the request fields and classify the miss when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_tag  <= '0;
            lat_idx  <= '0;
            lat_word <= '0;
            lat_kind <= OUT_COLD;
        end else if (start) begin
            lat_tag  <= req_tag;
            lat_idx  <= req_idx;
            lat_word <= req_word;
            lat_kind <= look_valid ? OUT_EVICT : OUT_COLD;
        end
    end

    // Response registers: a hit answers at once, a miss after its last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            resp_kind_q  <= OUT_HIT;
        end else begin
            resp_valid_q <= 1'b0;
            if (accept && hit) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= look_data;
                resp_kind_q  <= OUT_HIT;
            end
            if (beat && (word_cnt == lat_word))
                resp_data_q <= mem_rdata;
            if (last_beat) begin
                resp_valid_q <= 1'b1;
                resp_kind_q  <= lat_kind;
            end
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;
    assign resp_kind  = resp_kind_q;

    // R3: a hit answers on the next cycle with outcome 00.
    assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (resp_valid && resp_kind == 2'b00));

    // R3: a hit causes no memory read.
    assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> !mem_req);

    // R8: a miss response follows an acknowledged memory read.
    assert_miss_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind != 2'b00) |-> $past(mem_ack));

    // R8: the outcome code 11 never appears.
    assert_kind_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_kind != 2'b11));

    // R7: no request is taken while memory is being read.
    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
endmodule

// File: tb/tb_dmc_read_cache.sv
`timescale 1ns/1ps
module tb_dmc_read_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic [1:0]  resp_kind;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int checks = 0;
    int failures = 0;
    int nreads = 0;
    logic [31:0] rd_log [64];

    always #2.5 clk = ~clk;

    dmc_read_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_kind(resp_kind), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Backing memory contents: a fixed function of the word address.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ 32'h5A5A_1234;
    endfunction

    // Memory model: acknowledges every other cycle and logs each read.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            if (mem_req && mem_ack) begin
                rd_log[nreads % 64] = mem_addr;
                nreads = nreads + 1;
            end
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem_word(mem_addr);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One read: drive, wait for the pulse, check outcome, data, latency, memory reads.
    task automatic do_read(input logic [31:0] addr, input logic [1:0] exp_kind,
                           input string req);
        int base;
        int lat;
        logic [31:0] line_base;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        while (!req_ready) @(negedge clk);
        base = nreads;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (exp_kind != 2'b00)
            check(busy && !req_ready, "R7", "busy during refill", {30'd0, busy, req_ready}, 32'h2);
        while (!resp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(resp_valid, "R8", "response pulse seen", {31'd0, resp_valid}, 32'd1);
        check(resp_kind == exp_kind, req, "outcome", {30'd0, resp_kind}, {30'd0, exp_kind});
        check(resp_data == mem_word(addr), "R6", "data equals memory", resp_data, mem_word(addr));
        if (exp_kind == 2'b00) begin
            check(lat == 1, "R3", "hit latency", lat, 32'd1);
            check(nreads == base, "R3", "no memory read on hit", nreads - base, 32'd0);
        end else begin
            line_base = {addr[31:4], 4'h0};
            check(nreads - base == 4, "R4", "memory read count", nreads - base, 32'd4);
            for (int i = 0; i < 4; i++)
                check(rd_log[(base + i) % 64] == line_base + 32'(4 * i), "R4", "refill order",
                      rd_log[(base + i) % 64], line_base + 32'(4 * i));
        end
        @(negedge clk);
        check(!resp_valid, "R8", "single-cycle pulse", {31'd0, resp_valid}, 32'd0);
    endtask

    // Vector table: {expected outcome, address}. Outcome 00 hit, 01 cold, 10 evict.
    localparam int NVEC = 11;
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b01, 32'h0000_0014},  // R4 cold, index 1 tag 0
        {2'b00, 32'h0000_001C},  // R3 hit same line
        {2'b01, 32'h0000_0034},  // R4 cold, index 3
        {2'b10, 32'h0000_8014},  // R5 index 1, tag 2 evicts tag 0
        {2'b00, 32'h0000_0030},  // R9 index 3 untouched by index 1 refill
        {2'b10, 32'h0000_001C},  // R5 evicted tag misses again
        {2'b00, 32'h0000_001F},  // R2 byte bits ignored
        {2'b01, 32'hFFFF_FFFC},  // R2 top index, max tag
        {2'b00, 32'hFFFF_FFF0},  // R3 hit word 0 of top line
        {2'b10, 32'h0000_3FF0},  // R5 top index, tag 0
        {2'b00, 32'h0000_0010}   // R3 hit index 1
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(req_ready && !busy && !resp_valid && !mem_req, "R1", "reset outputs",
              {28'd0, req_ready, busy, resp_valid, mem_req}, 32'h8);

        for (int v = 0; v < NVEC; v++)
            do_read(VEC[v][31:0], VEC[v][33:32], "R2/R3/R4/R5");

        // R1: a second reset empties the cache again.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(32'h0000_0010, 2'b01, "R1");
        do_read(32'h0000_0018, 2'b00, "R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R8 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule